// File: doc/BRIEF.md
# Address Breakpoint Trap Injector

This block sits between the instruction fetch path and the instruction register of a small CPU. Every fetched opcode byte goes into a short prefetch queue together with one extra flag bit. While breakpoint generation is armed, a full-width comparator checks each fetch address against a programmable breakpoint address. A hit sets the flag bit of the entry that is fetched in that cycle.

The flag travels with its byte through the queue. The trap therefore happens when the flagged byte is handed to the instruction register, not when it is fetched. At that handover a multiplexer loads a trap opcode in place of the fetched byte and raises a single-cycle trap pulse. The CPU then vectors to a fixed trap address, which the block supplies as a constant output.

Arming and disarming are one-cycle command strobes. A flush input drops every queued entry along with its flag, for example on a taken branch. The CPU itself is outside the block. It asks for the next instruction with a pop request and receives a load strobe together with the new instruction register value.

Top module: `bp_trap_injector`

## Requirements
- R1: After reset, ir_out is 0x00, ir_load and trap_pulse are 0, q_empty is 1, q_full is 0, and breakpoints are disarmed: a fetch at the breakpoint address is not flagged.
- R2: While armed, a fetch is flagged only when all 24 bits of fetch_addr equal bp_addr. An address that differs in any single bit, including bit 23, is not flagged.
- R3: While disarmed, no fetch is flagged. A bp_enable_cmd or bp_disable_cmd strobe takes effect for fetches from the next cycle on. When both strobes are high in the same cycle, the block ends up disarmed.
- R4: The queue holds DEPTH entries (4 by default) and returns them in fetch order. q_full is 1 when it holds DEPTH entries and q_empty is 1 when it holds none. A fetch presented while the queue is full and no pop is accepted is dropped.
- R5: A pop request on a non-empty queue loads the head entry into the instruction register, and the result appears in the following cycle with ir_load high for one cycle. An unflagged entry loads its fetched byte and leaves trap_pulse low. A flagged entry loads TRAP_OP (0xF7 by default) and raises trap_pulse for that same single cycle.
- R6: flush empties the queue and clears all flags. In a flush cycle, pop and fetch are both ignored, so ir_out is unchanged and ir_load and trap_pulse stay low in the next cycle. A later pop finds nothing.
- R7: trap_vector always reads 0xFF2010.
- R8: The flag is fixed when the byte is fetched. Disarming after a flagged fetch does not prevent that entry's trap.
- R9: With a full queue, a pop and a fetch in the same cycle are both accepted. The queue stays full and the new byte goes behind the remaining entries.
- R10: A pop request on an empty queue leaves ir_out unchanged and ir_load low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A fetched byte is presented this cycle |
| fetch_addr | input | 24 | Address of the fetched byte |
| fetch_data | input | 8 | Fetched opcode byte |
| pop_req | input | 1 | Move the queue head into the instruction register |
| flush | input | 1 | Drop all queued entries and their flags |
| bp_addr | input | 24 | Breakpoint address |
| bp_enable_cmd | input | 1 | One-cycle strobe that arms breakpoints |
| bp_disable_cmd | input | 1 | One-cycle strobe that disarms breakpoints |
| ir_out | output | 8 | Instruction register |
| ir_load | output | 1 | Instruction register was loaded in the previous cycle |
| trap_pulse | output | 1 | The loaded instruction is the substituted trap |
| trap_vector | output | 24 | Fixed trap vector address |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |

## Verification
The collision that matters is a pop of a flagged head entry in the same cycle as a new fetch into a full queue. This cycle both substitutes the trap opcode and writes a fresh tag into the slot being freed. The bench fills the queue with a flagged byte at its head, then raises pop_req and fetch_valid together on one clock edge. It expects the trap opcode and the pulse from that pop, q_full still high, the remaining bytes in order, and the new byte last without a flag. A second collision, flush together with a pop of a flagged entry, must give no load and no pulse at all.

// File: rtl/bp_pkg.sv
package bp_pkg;
   localparam int OPC_W = 8;

   typedef logic [OPC_W-1:0] opcode_t;

   typedef struct packed {
      logic    flag;
      opcode_t op;
   } q_entry_t;
endpackage

// File: rtl/bp_match_unit.sv
module bp_match_unit #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_cmd,
   input  logic              dis_cmd,
   input  logic [ADDR_W-1:0] bp_addr,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              armed,
   output logic              hit
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (dis_cmd) armed_q <= 1'b0;
      else if (en_cmd)  armed_q <= 1'b1;
   end

   assign armed = armed_q;
   assign hit   = armed_q && (fetch_addr == bp_addr);

   AST_DISARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      dis_cmd |=> !armed); // R3
   AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (en_cmd && !dis_cmd) |=> armed); // R3
endmodule

// File: rtl/bp_tag_fifo.sv
module bp_tag_fifo
   import bp_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  q_entry_t push_entry,
   input  logic     pop,
   input  logic     flush,
   output q_entry_t head,
   output logic     pop_ok,
   output logic     full,
   output logic     empty
);
   localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W   = $clog2(DEPTH + 1);
   localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

   q_entry_t   mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             push_ok;

   generate
      if (IS_POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign pop_ok  = pop && !empty && !flush;
   assign push_ok = push && !flush && (!full || pop_ok);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i].flag <= 1'b0;
      end else begin
         if (push_ok) begin
            mem[wr_ptr] <= push_entry;
            wr_ptr      <= wr_nxt;
         end
         if (pop_ok) rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R4
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R6
   AST_SWAP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && pop && !flush) |=> full); // R9
endmodule

// File: rtl/bp_ir_stage.sv
module bp_ir_stage
   import bp_pkg::*;
#(
   parameter opcode_t TRAP_OP = 8'hF7
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load,
   input  q_entry_t entry,
   output opcode_t  ir,
   output logic     ir_load,
   output logic     trap
);
   opcode_t ir_q;
   logic    ld_q, trap_q;
   opcode_t mux_op;

   assign mux_op = entry.flag ? TRAP_OP : entry.op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q   <= '0;
         ld_q   <= 1'b0;
         trap_q <= 1'b0;
      end else begin
         ld_q   <= load;
         trap_q <= load && entry.flag;
         if (load) ir_q <= mux_op;
      end
   end

   assign ir      = ir_q;
   assign ir_load = ld_q;
   assign trap    = trap_q;

   AST_TRAP_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> ir_load); // R5
   AST_IR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ir)); // R10
endmodule

// File: rtl/bp_trap_injector.sv
module bp_trap_injector
   import bp_pkg::*;
#(
   parameter int          ADDR_W   = 24,
   parameter int          DEPTH    = 4,
   parameter logic [7:0]  TRAP_OP  = 8'hF7,
   parameter logic [23:0] TRAP_VEC = 24'hFF2010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [7:0]        fetch_data,
   input  logic              pop_req,
   input  logic              flush,
   input  logic [ADDR_W-1:0] bp_addr,
   input  logic              bp_enable_cmd,
   input  logic              bp_disable_cmd,
   output logic [7:0]        ir_out,
   output logic              ir_load,
   output logic              trap_pulse,
   output logic [23:0]       trap_vector,
   output logic              q_full,
   output logic              q_empty
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
         $error("ADDR_W must be 1 to 24");
      end
   endgenerate

   logic     hit, armed, pop_ok;
   q_entry_t in_entry, head;

   bp_match_unit #(.ADDR_W(ADDR_W)) u_match (
      .clk(clk), .rst_n(rst_n),
      .en_cmd(bp_enable_cmd), .dis_cmd(bp_disable_cmd),
      .bp_addr(bp_addr), .fetch_addr(fetch_addr),
      .armed(armed), .hit(hit)
   );

   assign in_entry.flag = hit;
   assign in_entry.op   = fetch_data;

   bp_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(fetch_valid), .push_entry(in_entry),
      .pop(pop_req), .flush(flush),
      .head(head), .pop_ok(pop_ok),
      .full(q_full), .empty(q_empty)
   );

   bp_ir_stage #(.TRAP_OP(TRAP_OP)) u_ir (
      .clk(clk), .rst_n(rst_n),
      .load(pop_ok), .entry(head),
      .ir(ir_out), .ir_load(ir_load), .trap(trap_pulse)
   );

   assign trap_vector = TRAP_VEC;

   AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_full && q_empty)); // R4
   AST_FLUSH_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!ir_load && !trap_pulse)); // R6
   AST_TRAP_IS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> (ir_out == TRAP_OP)); // R5
   AST_DISARMED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && fetch_valid && !q_full && !flush && pop_req && q_empty)
      |=> !trap_pulse); // R3
endmodule

// File: tb/bp_trap_injector_test.sv
module bp_trap_injector_test;
   localparam logic [7:0] TOP = 8'hF7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [23:0] fetch_addr = '0;
   logic [7:0]  fetch_data = '0;
   logic        pop_req = 1'b0;
   logic        flush = 1'b0;
   logic [23:0] bp_addr = 24'h123456;
   logic        bp_enable_cmd = 1'b0;
   logic        bp_disable_cmd = 1'b0;
   logic [7:0]  ir_out;
   logic        ir_load, trap_pulse, q_full, q_empty;
   logic [23:0] trap_vector;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bp_trap_injector uut (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
      .pop_req(pop_req), .flush(flush), .bp_addr(bp_addr),
      .bp_enable_cmd(bp_enable_cmd), .bp_disable_cmd(bp_disable_cmd),
      .ir_out(ir_out), .ir_load(ir_load), .trap_pulse(trap_pulse),
      .trap_vector(trap_vector), .q_full(q_full), .q_empty(q_empty)
   );

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic fetch(logic [23:0] a, logic [7:0] d);
      fetch_valid = 1'b1; fetch_addr = a; fetch_data = d;
      cyc();
      fetch_valid = 1'b0;
   endtask

   task automatic arm();
      bp_enable_cmd = 1'b1; cyc(); bp_enable_cmd = 1'b0;
   endtask

   task automatic disarm();
      bp_disable_cmd = 1'b1; cyc(); bp_disable_cmd = 1'b0;
   endtask

   task automatic pop_expect(string req, logic [7:0] op, logic trap);
      pop_req = 1'b1; cyc(); pop_req = 1'b0;
      check(req, "ir_out", ir_out, op);
      check(req, "ir_load", ir_load, 1);
      check(req, "trap_pulse", trap_pulse, trap);
   endtask

   task automatic t_reset();
      check("R1", "ir_out", ir_out, 0);
      check("R1", "ir_load", ir_load, 0);
      check("R1", "trap_pulse", trap_pulse, 0);
      check("R1", "q_empty", q_empty, 1);
      check("R1", "q_full", q_full, 0);
      check("R7", "trap_vector", trap_vector, 24'hFF2010);
      fetch(24'h123456, 8'h3C);
      pop_expect("R1", 8'h3C, 0);
   endtask

   task automatic t_match();
      arm();
      fetch(24'h123456, 8'h11);
      pop_expect("R2", TOP, 1);
      cyc();
      check("R5", "trap one cycle", trap_pulse, 0);
      check("R5", "load one cycle", ir_load, 0);
      fetch(24'h123457, 8'h22);
      pop_expect("R2", 8'h22, 0);
      fetch(24'h923456, 8'h33);
      pop_expect("R2", 8'h33, 0);
   endtask

   task automatic t_disarm();
      disarm();
      fetch(24'h123456, 8'h44);
      pop_expect("R3", 8'h44, 0);
      bp_enable_cmd = 1'b1; bp_disable_cmd = 1'b1; cyc();
      bp_enable_cmd = 1'b0; bp_disable_cmd = 1'b0;
      fetch(24'h123456, 8'h45);
      pop_expect("R3", 8'h45, 0);
   endtask

   task automatic t_tag_sticks();
      arm();
      fetch(24'h123456, 8'h55);
      disarm();
      pop_expect("R8", TOP, 1);
   endtask

   task automatic t_order_full();
      fetch(24'h000001, 8'hA1);
      fetch(24'h000002, 8'hA2);
      fetch(24'h000003, 8'hA3);
      fetch(24'h000004, 8'hA4);
      check("R4", "q_full", q_full, 1);
      fetch(24'h000005, 8'hA5);
      pop_expect("R4", 8'hA1, 0);
      pop_expect("R4", 8'hA2, 0);
      pop_expect("R4", 8'hA3, 0);
      pop_expect("R4", 8'hA4, 0);
      check("R4", "q_empty", q_empty, 1);
      pop_req = 1'b1; cyc(); pop_req = 1'b0;
      check("R10", "ir_load on empty", ir_load, 0);
      check("R10", "ir_out held", ir_out, 8'hA4);
   endtask

   task automatic t_swap_full();
      arm();
      fetch(24'h123456, 8'hB1);
      fetch(24'h000011, 8'hB2);
      fetch(24'h000012, 8'hB3);
      fetch(24'h000013, 8'hB4);
      pop_req = 1'b1; fetch_valid = 1'b1; fetch_addr = 24'h000014; fetch_data = 8'hB5;
      cyc();
      pop_req = 1'b0; fetch_valid = 1'b0;
      check("R9", "ir_out", ir_out, TOP);
      check("R9", "trap_pulse", trap_pulse, 1);
      check("R9", "q_full", q_full, 1);
      pop_expect("R9", 8'hB2, 0);
      pop_expect("R9", 8'hB3, 0);
      pop_expect("R9", 8'hB4, 0);
      pop_expect("R9", 8'hB5, 0);
      check("R9", "q_empty", q_empty, 1);
   endtask

   task automatic t_flush();
      fetch(24'h123456, 8'hC1);
      fetch(24'h123456, 8'hC2);
      flush = 1'b1; pop_req = 1'b1; cyc();
      flush = 1'b0; pop_req = 1'b0;
      check("R6", "ir_load", ir_load, 0);
      check("R6", "trap_pulse", trap_pulse, 0);
      check("R6", "ir_out held", ir_out, 8'hB5);
      check("R6", "q_empty", q_empty, 1);
      pop_req = 1'b1; cyc(); pop_req = 1'b0;
      check("R6", "pop after flush", ir_load, 0);
      disarm();
      fetch(24'h000020, 8'hC3);
      pop_expect("R6", 8'hC3, 0);
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_match();
      t_disarm();
      t_tag_sticks();
      t_order_full();
      t_swap_full();
      t_flush();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule